// File: doc/BRIEF.md
# PHY Reset Pulse Sequencer

This block drives the reset pin of an external PHY through a timed three-phase pattern. The pin is first held at its inactive level, then driven active, then released, and a one-clock completion pulse follows. Each phase waits for its own configured delay. Delays are given in microseconds and rounded up to whole milliseconds before they are applied. A phase whose delay is zero is skipped without costing a clock.

Time is counted from a one-clock-wide microsecond tick supplied by the surrounding logic. Polarity is chosen at runtime. When active-low is selected, the inactive level is 1 and the active level is 0; otherwise the levels are swapped. A start pulse captures the three delays and the polarity, so the inputs may change freely while the pattern runs. Start pulses that arrive during a running sequence are ignored.

Top module: `phy_rst_seq`

## Requirements
- R1: While reset is applied, and in idle after it, `done_o` is 0 and `rst_pin_o` equals `active_low_i`, which is the inactive level for the live polarity.
- R2: With the captured polarity bit at 1, the pin is 1 when inactive and 0 when active; with it at 0, the pin is 0 when inactive and 1 when active.
- R3: A start pulse sampled in idle begins the pattern on that edge. The pin is inactive during phase 0, active during phase 1 and inactive during phase 2, in that order.
- R4: Phase k lasts Tk = ceil(dk / US_PER_MS) * US_PER_MS tick pulses, where dk is the delay input for that phase. It ends on the clock edge that samples its Tk-th tick.
- R5: A phase with a delay of zero takes no clock cycles; the next non-zero phase starts on the same edge.
- R6: `done_o` is high for exactly one clock, starting on the edge where the last non-skipped phase ends. If all three delays are zero, it starts on the start edge itself.
- R7: A start pulse received while a sequence is running has no effect on the pin, on the timing or on `done_o`.
- R8: The delays and the polarity are captured at start. Changing those inputs during a sequence does not alter the running pattern.
- R9: While `us_tick_i` is low, a running phase does not advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a sequence (taken only in idle) |
| active_low_i | input | 1 | 1: reset pin is active low |
| dly0_i | input | DLY_W | Pre-assert delay in microseconds |
| dly1_i | input | DLY_W | Assert width in microseconds |
| dly2_i | input | DLY_W | Post-release delay in microseconds |
| us_tick_i | input | 1 | One-clock pulse per microsecond |
| rst_pin_o | output | 1 | Reset pin level |
| done_o | output | 1 | One-clock completion pulse |

## Verification
The bench sweeps every combination of the three delays over 0 to 9 under both polarities, with a small milliseconds divisor. This covers delays that are zero, delays below one rounding step, delays exactly on a step and delays just past one. The pin and the done pulse are compared against arithmetic phase boundaries. The sweep therefore separates wrong rounding, wrong skipping of a zero phase, wrong phase order and an off-by-one end edge. Two directed runs follow. One fires extra start pulses and changes polarity and delays mid-run, which separates capture at start from live use of the inputs. The other holds the tick low, which shows that a phase stalls rather than running on the clock.

// File: rtl/phy_rst_seq.sv
module phy_rst_seq #(
  parameter int DLY_W     = 20,
  parameter int US_PER_MS = 1000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             active_low_i,
  input  logic [DLY_W-1:0] dly0_i,
  input  logic [DLY_W-1:0] dly1_i,
  input  logic [DLY_W-1:0] dly2_i,
  input  logic             us_tick_i,
  output logic             rst_pin_o,
  output logic             done_o
);

  localparam int CNT_W = DLY_W + 1 + $clog2(US_PER_MS + 1);
  localparam logic [CNT_W-1:0] STEP = CNT_W'(US_PER_MS);
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

  typedef enum logic [1:0] {S_IDLE, S_PH0, S_PH1, S_PH2} state_t;

  state_t           state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [DLY_W-1:0] d0_q, d1_q, d2_q;
  logic             pol_q, done_d;
  logic             busy, advance, take;
  logic [DLY_W-1:0] s0, s1, s2;
  logic [CNT_W-1:0] r0, r1, r2;
  logic             en0, en1, en2;

  function automatic logic [CNT_W-1:0] round_up(input logic [DLY_W-1:0] d);
    logic [CNT_W-1:0] dd;
    dd = CNT_W'(d);
    return ((dd + STEP - ONE) / STEP) * STEP;
  endfunction

  assign busy = (state_q != S_IDLE);
  assign take = !busy && start_i;

  assign s0 = busy ? d0_q : dly0_i;
  assign s1 = busy ? d1_q : dly1_i;
  assign s2 = busy ? d2_q : dly2_i;

  assign r0 = round_up(s0);
  assign r1 = round_up(s1);
  assign r2 = round_up(s2);

  assign en0 = (state_q == S_IDLE) && (r0 != '0);
  assign en1 = ((state_q == S_IDLE) || (state_q == S_PH0)) && (r1 != '0);
  assign en2 = (state_q != S_PH2) && (r2 != '0);

  assign advance = take || (busy && us_tick_i && (cnt_q == ONE));

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    done_d  = 1'b0;
    if (advance) begin
      if (en0) begin
        state_d = S_PH0;
        cnt_d   = r0;
      end else if (en1) begin
        state_d = S_PH1;
        cnt_d   = r1;
      end else if (en2) begin
        state_d = S_PH2;
        cnt_d   = r2;
      end else begin
        state_d = S_IDLE;
        cnt_d   = '0;
        done_d  = 1'b1;
      end
    end else if (busy && us_tick_i) begin
      cnt_d = cnt_q - ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      cnt_q   <= '0;
      done_o  <= 1'b0;
      pol_q   <= 1'b0;
      d0_q    <= '0;
      d1_q    <= '0;
      d2_q    <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      done_o  <= done_d;
      if (take) begin
        pol_q <= active_low_i;
        d0_q  <= dly0_i;
        d1_q  <= dly1_i;
        d2_q  <= dly2_i;
      end
    end
  end

  assign rst_pin_o = (busy ? pol_q : active_low_i) ^ (state_q == S_PH1);

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !start_i) |=> !done_o); // R6
  AST_DONE_IN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (state_q == S_IDLE || $past(start_i))); // R6
  AST_STALL_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !us_tick_i) |=> ($stable(cnt_q) && $stable(state_q))); // R9
  AST_POL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (!busy || $stable(pol_q))); // R8
  AST_CNT_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (cnt_q != '0)); // R4
  AST_NO_BACK_FROM_PH1: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_PH1) |=> (state_q != S_PH0)); // R3
  AST_NO_BACK_FROM_PH2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_PH2) |=> (state_q == S_PH2 || state_q == S_IDLE)); // R3
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start_i && !us_tick_i) |=> $stable(state_q)); // R7

endmodule

// File: tb/phy_rst_seq_tb.sv
`timescale 1ns/1ps
module phy_rst_seq_tb_top;
  localparam int DW = 5;
  localparam int U  = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start_i = 1'b0;
  logic          active_low_i = 1'b0;
  logic [DW-1:0] dly0_i = '0, dly1_i = '0, dly2_i = '0;
  logic          us_tick_i = 1'b1;
  logic          rst_pin_o, done_o;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  always #2.5 clk = ~clk;

  phy_rst_seq #(.DLY_W(DW), .US_PER_MS(U)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .active_low_i(active_low_i),
    .dly0_i(dly0_i), .dly1_i(dly1_i), .dly2_i(dly2_i), .us_tick_i(us_tick_i),
    .rst_pin_o(rst_pin_o), .done_o(done_o));

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog expired: actual cycles %0d, expected below 150000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  function automatic int rnd(input int d);
    return ((d + U - 1) / U) * U;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic run_case(input int a, input int b, input int c, input bit pol);
    int t0, t1, t2, tt;
    int pin_bad, done_bad, first_pin, first_done;
    t0 = rnd(a); t1 = rnd(b); t2 = rnd(c); tt = t0 + t1 + t2;
    pin_bad = 0; done_bad = 0; first_pin = -1; first_done = -1;
    @(negedge clk);
    active_low_i = pol;
    dly0_i = DW'(a); dly1_i = DW'(b); dly2_i = DW'(c);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    for (int k = 0; k <= tt + 2; k++) begin
      bit exp_pin;
      if (k > 0) @(negedge clk);
      exp_pin = pol ^ ((k >= t0) && (k < t0 + t1));
      if (rst_pin_o !== exp_pin) begin
        pin_bad++;
        if (first_pin < 0) first_pin = k;
      end
      if (done_o !== (k == tt)) begin
        done_bad++;
        if (first_done < 0) first_done = k;
      end
    end
    // R2 R3 R4 R5: pin follows the three phases with rounded lengths
    chk(pin_bad == 0, $sformatf("R3 R4 R5 R2 pin d=%0d,%0d,%0d pol=%0d first bad k", a, b, c, pol),
        first_pin, -1);
    // R6: one-clock done at the end of the last phase
    chk(done_bad == 0, $sformatf("R6 done d=%0d,%0d,%0d pol=%0d first bad k", a, b, c, pol),
        first_done, -1);
  endtask

  initial begin
    int bad, firstk;
    // R1: reset state for both polarities
    #1;
    chk(rst_pin_o === 1'b0 && done_o === 1'b0, "R1 reset pol=0 pin", int'(rst_pin_o), 0);
    active_low_i = 1'b1;
    #1;
    chk(rst_pin_o === 1'b1 && done_o === 1'b0, "R1 reset pol=1 pin", int'(rst_pin_o), 1);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(rst_pin_o === 1'b1 && done_o === 1'b0, "R1 idle after reset pin", int'(rst_pin_o), 1);

    for (int p = 0; p < 2; p++)
      for (int a = 0; a < 10; a++)
        for (int b = 0; b < 10; b++)
          for (int c = 0; c < 10; c++)
            run_case(a, b, c, p[0]);

    // R7 R8: extra starts and input changes while running
    bad = 0; firstk = -1;
    @(negedge clk);
    active_low_i = 1'b0;
    dly0_i = 5; dly1_i = 5; dly2_i = 5;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    for (int k = 0; k <= 27; k++) begin
      bit ep;
      if (k > 0) @(negedge clk);
      ep = (k >= 24) ? 1'b1 : ((k >= 8) && (k < 16));
      if (rst_pin_o !== ep || done_o !== (k == 24)) begin
        bad++;
        if (firstk < 0) firstk = k;
      end
      if (k == 3) start_i = 1'b1;
      if (k == 4) start_i = 1'b0;
      if (k == 10) begin
        start_i = 1'b1;
        active_low_i = 1'b1;
        dly0_i = 0; dly1_i = 0; dly2_i = 0;
      end
      if (k == 11) start_i = 1'b0;
    end
    chk(bad == 0, "R7 R8 mid-run start and input change, first bad k", firstk, -1);

    // R9: no tick, no progress
    bad = 0; firstk = -1;
    @(negedge clk);
    active_low_i = 1'b0;
    dly0_i = 4; dly1_i = 0; dly2_i = 0;
    us_tick_i = 1'b0;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    for (int k = 0; k <= 26; k++) begin
      if (k > 0) @(negedge clk);
      if (rst_pin_o !== 1'b0 || done_o !== (k == 24)) begin
        bad++;
        if (firstk < 0) firstk = k;
      end
      if (k == 20) us_tick_i = 1'b1;
    end
    chk(bad == 0, "R9 stalled tick, first bad k", firstk, -1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule